// File: doc/BRIEF.md
# Board Interrupt Request Register Bank

This block holds the byte-wide control registers that the local processor of a network node card uses to raise its own interrupts. The processor reaches them over a 16-bit big-endian bus. Each register sits at a fixed, word-aligned offset of the board register page, and only the low byte lane carries data. There are eight registers: a master interrupt enable, four interrupt source registers, an exception register, a control/status register and a memory-map select register.

Four level-sensitive interrupt request lines go to a 68000-class processor. The utility source drives level 2, the host source level 3, the transmit source level 4 and the receive source level 5. Bit 7 of each source register raises its line, but only while bit 7 of the enable register is set. The request lines are registered. Each line takes its new value on the same clock edge that stores a write to the bank, so the processor sees the new level one cycle after it issues the write.

Two bits of the control/status register drive the fail and run indicators. Bit 7 of the memory-map select register picks which boot memory view the board decodes. Any access to the soft-reset offset clears the whole bank and emits a one-cycle reset pulse to the rest of the board.

Top module: `irq_reg_bank`

## Requirements
- R1: After `rst_n` is released, all eight registers read 0, and `irq_lvl`, `fail_led`, `run_led`, `boot_map_sel` and `soft_rst` are all 0.
- R2: While bit 7 of the enable register is 0, `irq_lvl` is 4'b0000, whatever the source registers hold.
- R3: While the enable bit 7 is 1, `irq_lvl[0]` (level 2) equals bit 7 of the utility register and `irq_lvl[1]` (level 3) equals bit 7 of the host register.
- R4: While the enable bit 7 is 1, `irq_lvl[2]` (level 4) equals bit 7 of the transmit register and `irq_lvl[3]` (level 5) equals bit 7 of the receive register.
- R5: Registers decode at these byte offsets, with `bus_addr[0]` ignored: enable 0x0C0, transmit 0x0C2, receive 0x0C4, utility 0x0C6, memory-map select 0x0CE, control/status 0x0A0, exception 0x0E0, host 0xE00. A write stores `bus_wdata[7:0]`. A read returns the stored byte in `bus_rdata[7:0]`, with `bus_rdata[15:8]` = 0.
- R6: A write takes effect on the rising edge where `bus_sel` and `bus_we` are both high. `irq_lvl` shows the result of that write from the same edge onward, and does not change on edges without an access.
- R7: `fail_led` follows bit 6 of the control/status register, and `run_led` follows bit 5.
- R8: A read or write with `bus_sel` high at offset 0xF00 returns 0 on `bus_rdata`. On that edge it clears all eight registers and `irq_lvl`, and it drives `soft_rst` high for exactly one cycle.
- R9: Bits 6..0 of the source registers and of the enable register are stored and read back, but they have no effect on `irq_lvl`.
- R10: `boot_map_sel` follows bit 7 of the memory-map select register.
- R11: A read at an unmapped offset returns 0, and a write there changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset within the board register page |
| bus_wdata | input | 16 | Write data; only bits 7..0 are used |
| bus_rdata | output | 16 | Read data, valid in the cycle `bus_sel` is high |
| irq_lvl | output | 4 | Interrupt requests, levels 2..5 on bits 0..3 |
| fail_led | output | 1 | Fail indicator |
| run_led | output | 1 | Run indicator |
| boot_map_sel | output | 1 | Boot memory view select |
| soft_rst | output | 1 | One-cycle board soft-reset pulse |

## Verification
The bench builds the bank with its default 12-bit offset width and default register offsets. At that width the host register at 0xE00 and the soft-reset offset at 0xF00 are decoded on their full address, so aliasing of the upper page against the 0x0C0 group can be observed. A 16-entry table covers every pattern of the four source bits 7, with the other bits filled with varying noise. The table is walked once with the global enable clear and once with it set. Directed tests then cover readback of the upper lane, the indicator bits, the map-select bit, unmapped offsets, soft reset by both a read and a write, and the edge at which each line turns on and off.

// File: rtl/irq_reg_bank.sv
module irq_reg_bank #(
  parameter int AW = 12,
  parameter logic [AW-1:0] OFF_IEN  = 12'h0C0,
  parameter logic [AW-1:0] OFF_TX   = 12'h0C2,
  parameter logic [AW-1:0] OFF_RX   = 12'h0C4,
  parameter logic [AW-1:0] OFF_UTL  = 12'h0C6,
  parameter logic [AW-1:0] OFF_EXC  = 12'h0E0,
  parameter logic [AW-1:0] OFF_CTL  = 12'h0A0,
  parameter logic [AW-1:0] OFF_MAP  = 12'h0CE,
  parameter logic [AW-1:0] OFF_HOST = 12'hE00,
  parameter logic [AW-1:0] OFF_SRST = 12'hF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic [3:0]    irq_lvl,
  output logic          fail_led,
  output logic          run_led,
  output logic          boot_map_sel,
  output logic          soft_rst
);
  localparam int NREG = 8;
  localparam int I_IEN = 0, I_TX = 1, I_RX = 2, I_UTL = 3,
                 I_EXC = 4, I_CTL = 5, I_MAP = 6, I_HOST = 7;
  localparam logic [AW-1:0] OFFS [NREG] =
    '{OFF_IEN, OFF_TX, OFF_RX, OFF_UTL, OFF_EXC, OFF_CTL, OFF_MAP, OFF_HOST};

  logic [7:0]      regs_q [NREG];
  logic [7:0]      regs_d [NREG];
  logic [NREG-1:0] hit;
  logic [3:0]      irq_q;
  logic            srst_q;
  logic            srst_hit;

  assign srst_hit = bus_sel && (bus_addr[AW-1:1] == OFF_SRST[AW-1:1]);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hit[i] = bus_sel && (bus_addr[AW-1:1] == OFFS[i][AW-1:1]);
      if (srst_hit)             regs_d[i] = 8'h00;
      else if (hit[i] && bus_we) regs_d[i] = bus_wdata[7:0];
      else                      regs_d[i] = regs_q[i];
    end
  end

  always_comb begin
    bus_rdata = 16'h0000;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) bus_rdata[7:0] = regs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
      irq_q  <= 4'b0000;
      srst_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      irq_q  <= {4{regs_d[I_IEN][7]}} &
                {regs_d[I_RX][7], regs_d[I_TX][7], regs_d[I_HOST][7], regs_d[I_UTL][7]};
      srst_q <= srst_hit;
    end
  end

  assign irq_lvl      = irq_q;
  assign soft_rst     = srst_q;
  assign fail_led     = regs_q[I_CTL][6];
  assign run_led      = regs_q[I_CTL][5];
  assign boot_map_sel = regs_q[I_MAP][7];

  assert_gate_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[I_IEN][7] |-> irq_lvl == 4'b0000);

  assert_low_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[I_IEN][7] |-> (irq_lvl[0] == regs_q[I_UTL][7] && irq_lvl[1] == regs_q[I_HOST][7]));

  assert_high_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[I_IEN][7] |-> (irq_lvl[2] == regs_q[I_TX][7] && irq_lvl[3] == regs_q[I_RX][7]));

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(irq_lvl));

  assert_srst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (soft_rst && irq_lvl == 4'b0000 && regs_q[I_IEN] == 8'h00));

  assert_srst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !srst_hit |=> !soft_rst);

  assert_srst_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |-> bus_rdata == 16'h0000);

  assert_one_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/irq_reg_bank_bench.sv
module irq_reg_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_lvl;
  logic        fail_led, run_led, boot_map_sel, soft_rst;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_reg_bank u_irq_reg_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl(irq_lvl), .fail_led(fail_led), .run_led(run_led),
    .boot_map_sel(boot_map_sel), .soft_rst(soft_rst)
  );

  localparam logic [11:0] A_IEN = 12'h0C0, A_TX = 12'h0C2, A_RX = 12'h0C4,
    A_UTL = 12'h0C6, A_MAP = 12'h0CE, A_CTL = 12'h0A0, A_EXC = 12'h0E0,
    A_HOST = 12'hE00, A_SRST = 12'hF00;

  // {source pattern: bit0 util, bit1 host, bit2 tx, bit3 rx ; 7-bit noise}
  localparam logic [10:0] VEC [16] = '{
    {4'h0, 7'h15}, {4'h1, 7'h2A}, {4'h2, 7'h7F}, {4'h3, 7'h01},
    {4'h4, 7'h40}, {4'h5, 7'h33}, {4'h6, 7'h0C}, {4'h7, 7'h55},
    {4'h8, 7'h6E}, {4'h9, 7'h00}, {4'hA, 7'h12}, {4'hB, 7'h7E},
    {4'hC, 7'h21}, {4'hD, 7'h4B}, {4'hE, 7'h39}, {4'hF, 7'h66}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {12'h0, irq_lvl}, 16'h0);
    check("R1 pins", {12'h0, fail_led, run_led, boot_map_sel, soft_rst}, 16'h0);
    foreach (VEC[k]) begin end
    rd(A_IEN, r);  check("R1 ien", r, 16'h0);
    rd(A_TX, r);   check("R1 tx", r, 16'h0);
    rd(A_RX, r);   check("R1 rx", r, 16'h0);
    rd(A_UTL, r);  check("R1 utl", r, 16'h0);
    rd(A_EXC, r);  check("R1 exc", r, 16'h0);
    rd(A_CTL, r);  check("R1 ctl", r, 16'h0);
    rd(A_MAP, r);  check("R1 map", r, 16'h0);
    rd(A_HOST, r); check("R1 host", r, 16'h0);

    // Table walk: R2 with gate clear, R3/R4/R9 with gate set
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 16; i++) begin
        logic [3:0] p;
        logic [6:0] n;
        p = VEC[i][10:7];
        n = VEC[i][6:0];
        wr(A_UTL,  {8'hA5, p[0], n});
        wr(A_HOST, {8'h5A, p[1], ~n});
        wr(A_TX,   {8'hFF, p[2], n ^ 7'h2B});
        wr(A_RX,   {8'h00, p[3], n ^ 7'h54});
        wr(A_IEN,  {8'h00, g[0], n});
        if (g == 0) check("R2 gate closed", {12'h0, irq_lvl}, 16'h0);
        else begin
          check("R3 util/host levels", {14'h0, irq_lvl[1:0]}, {14'h0, p[1:0]});
          check("R4 tx/rx levels", {14'h0, irq_lvl[3:2]}, {14'h0, p[3:2]});
        end
        rd(A_HOST, r); check("R9 host readback", r, {8'h00, p[1], ~n});
        rd(A_IEN, r);  check("R9 ien readback", r, {8'h00, g[0], n});
      end
    end

    // R6: turn-on and turn-off timing, no change on idle edges
    wr(A_IEN, 16'h0000);
    wr(A_UTL, 16'h0000); wr(A_HOST, 16'h0000); wr(A_TX, 16'h0000); wr(A_RX, 16'h0000);
    wr(A_IEN, 16'h0080);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_TX; bus_wdata = 16'h0080;
    #1 check("R6 before edge", {12'h0, irq_lvl}, 16'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check("R6 after edge", {12'h0, irq_lvl}, 16'h0004);
    repeat (3) @(negedge clk);
    check("R6 idle stable", {12'h0, irq_lvl}, 16'h0004);
    wr(A_IEN, 16'h007F);
    check("R6 gate off", {12'h0, irq_lvl}, 16'h0);
    wr(A_IEN, 16'h0080);
    check("R6 gate on", {12'h0, irq_lvl}, 16'h0004);

    // R5: upper lane ignored, odd byte address alias
    wr(A_EXC, 16'hC3E7);
    rd(A_EXC, r); check("R5 exc low lane", r, 16'h00E7);
    rd(A_EXC | 12'h001, r); check("R5 odd addr", r, 16'h00E7);
    wr(A_RX | 12'h001, 16'h0080);
    check("R5 odd write rx", {12'h0, irq_lvl}, 16'h000C);

    // R7 indicators
    wr(A_CTL, 16'h0040);
    check("R7 fail", {14'h0, fail_led, run_led}, 16'h0002);
    wr(A_CTL, 16'h0020);
    check("R7 run", {14'h0, fail_led, run_led}, 16'h0001);
    wr(A_CTL, 16'h009F);
    check("R7 off", {14'h0, fail_led, run_led}, 16'h0000);

    // R10 map select
    wr(A_MAP, 16'h0080);
    check("R10 map on", {15'h0, boot_map_sel}, 16'h0001);
    wr(A_MAP, 16'h007F);
    check("R10 map off", {15'h0, boot_map_sel}, 16'h0000);

    // R11 unmapped
    wr(12'h0C8, 16'h00FF);
    wr(12'h000, 16'h00FF);
    check("R11 no irq change", {12'h0, irq_lvl}, 16'h000C);
    rd(12'h0C8, r); check("R11 read zero", r, 16'h0);
    rd(A_MAP, r);   check("R11 map kept", r, 16'h007F);

    // R8 soft reset by read
    wr(A_CTL, 16'h0060);
    rd(A_SRST, r);
    check("R8 read returns 0", r, 16'h0);
    check("R8 pulse", {15'h0, soft_rst}, 16'h0001);
    check("R8 irq cleared", {12'h0, irq_lvl}, 16'h0);
    check("R8 leds cleared", {14'h0, fail_led, run_led}, 16'h0);
    @(negedge clk);
    check("R8 single pulse", {15'h0, soft_rst}, 16'h0);
    rd(A_TX, r);  check("R8 tx cleared", r, 16'h0);
    rd(A_IEN, r); check("R8 ien cleared", r, 16'h0);

    // R8 soft reset by write
    wr(A_IEN, 16'h0080); wr(A_UTL, 16'h0080);
    check("R3 util alone", {12'h0, irq_lvl}, 16'h0001);
    wr(A_SRST, 16'h00FF);
    check("R8 write pulse", {15'h0, soft_rst}, 16'h0001);
    check("R8 write clears irq", {12'h0, irq_lvl}, 16'h0);
    rd(A_UTL, r); check("R8 utl cleared", r, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule